// File: doc/BRIEF.md
# Break and Abort Detector

This block watches the receive side of a serial channel and keeps one status bit that reports a line break (asynchronous mode) or an abort sequence (bit-oriented synchronous mode). It reports both the start and the end of each condition. Each edge of the status bit can raise an external/status interrupt. Between the two edges the detector waits for a re-arm command from software, so each interrupt is handled before the next edge is looked for.

In asynchronous mode the detector takes each assembled character together with its framing-error flag, and also takes the raw sampled line bits. A break starts with an all-zero character that carries a framing error. The break ends at the first line bit sampled high. After the break ends, one all-zero character is still left in the receiver. A hint output tells software to read that character and throw it away.

In bit-oriented mode the detector counts consecutive ones on the strobed receive stream. Seven or more ones start an abort, and the first zero after that ends it. A channel-reset strobe and the asynchronous hardware reset both clear everything and leave the detector armed. The other synchronous modes leave the status bit unused.

Top module: `brk_abort_det`

## Requirements
- R1: With `mode` = 2'b00 (asynchronous) and the detector armed, a `char_vld` pulse with `char_data` all zero and `frame_err` = 1 sets `brk_stat` one cycle later.
- R2: In asynchronous mode, a character that is non-zero, or that is zero but has `frame_err` = 0, leaves `brk_stat` at 0.
- R3: With `mode` = 2'b01 (bit-oriented), the seventh consecutive `bit_stb` with `bit_val` = 1 sets `brk_stat` one cycle later. Six ones followed by a zero do not set it.
- R4: Each start or end event sets `irq_pend` one cycle later if `irq_en` is 1 in the cycle of the event, and leaves it unchanged if `irq_en` is 0. `irq_pend` stays high until a `rearm` pulse clears it. An event in the same cycle as `rearm` wins.
- R5: After a start event, end conditions are ignored and `brk_stat` stays 1 until a `rearm` pulse has been given.
- R6: Once re-armed after a start, the end is found as follows. In asynchronous mode it is the first `bit_stb` with `bit_val` = 1. In bit-oriented mode it is the first `bit_stb` with `bit_val` = 0. The end clears `brk_stat` one cycle later.
- R7: After an end event, start conditions are ignored until another `rearm` pulse has been given.
- R8: An end event in asynchronous mode sets `discard_hint` one cycle later. The hint clears one cycle after the next `char_vld`. A bit-oriented end never sets it.
- R9: `rst_n` low or a `chan_rst` pulse clears `brk_stat`, `irq_pend` and `discard_hint` and leaves the detector armed for a start.
- R10: With `mode` = 2'b10 or 2'b11 (other synchronous modes), no input changes `brk_stat`.
- R11: The ones count saturates, so ones beyond the seventh cause no second event. Any zero bit clears the count, and the count is also held clear outside bit-oriented mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| chan_rst | input | 1 | Synchronous channel reset strobe |
| mode | input | 2 | 00 asynchronous, 01 bit-oriented, 1x other synchronous |
| char_vld | input | 1 | Assembled character strobe |
| char_data | input | CHAR_W | Assembled character |
| frame_err | input | 1 | Framing error of the character |
| bit_stb | input | 1 | Receive bit strobe |
| bit_val | input | 1 | Sampled receive bit |
| rearm | input | 1 | Reset-external/status command strobe |
| irq_en | input | 1 | External/status interrupt enable |
| brk_stat | output | 1 | Break/abort status |
| irq_pend | output | 1 | External/status interrupt pending |
| discard_hint | output | 1 | Next received character is the spurious null |

## Verification
The bench targets several edge cases, and each one has a typical failure it would expose.
- Six ones followed by a zero, then a seventh one, must not trigger. An off-by-one counter would fire early.
- A run of ones past seven must not re-trigger. A counter that does not saturate or wraps would fire a second time.
- A line "one" arriving before the re-arm must be ignored. A level-following detector would clear the status at once.
- An event in the same cycle as `rearm` must still raise the interrupt, which catches a wrong priority.
- The null character after a break must drop `discard_hint` only when that character arrives.
- The other synchronous modes, and a disabled interrupt, must stay silent.

// File: rtl/brk_abort_pkg.sv
package brk_abort_pkg;

   typedef enum logic [1:0] {
      MODE_ASYNC = 2'b00,
      MODE_BITOR = 2'b01,
      MODE_SYNA  = 2'b10,
      MODE_SYNB  = 2'b11
   } brk_mode_e;

   typedef enum logic [1:0] {
      ST_SEEK_START = 2'b00,
      ST_HOLD_START = 2'b01,
      ST_SEEK_END   = 2'b10,
      ST_HOLD_END   = 2'b11
   } brk_state_e;

endpackage

// File: rtl/brk_ones_cnt.sv
module brk_ones_cnt #(
   parameter int ONES_LIM = 7,
   parameter int CNT_W    = $clog2(ONES_LIM + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic stb,
   input  logic bit_val,
   output logic at_thresh
);
   localparam logic [CNT_W-1:0] LIM_C  = CNT_W'(ONES_LIM);
   localparam logic [CNT_W-1:0] EDGE_C = CNT_W'(ONES_LIM - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (stb) begin
         if (!bit_val)
            cnt_q <= '0;
         else if (cnt_q != LIM_C)
            cnt_q <= cnt_q + 1'b1;
      end
   end

   assign at_thresh = (cnt_q >= EDGE_C);
endmodule

// File: rtl/brk_evt_dec.sv
module brk_evt_dec
   import brk_abort_pkg::*;
#(
   parameter int CHAR_W  = 8,
   parameter bit BITOR_EN = 1'b1
) (
   input  brk_mode_e         mode,
   input  logic              char_vld,
   input  logic [CHAR_W-1:0] char_data,
   input  logic              frame_err,
   input  logic              bit_stb,
   input  logic              bit_val,
   input  logic              ones_at_thresh,
   output logic              start_cond,
   output logic              end_cond,
   output logic              async_end
);
   logic async_start;
   logic bor_start;
   logic bor_end;

   assign async_start = (mode == MODE_ASYNC) && char_vld && (char_data == '0) && frame_err;
   assign async_end   = (mode == MODE_ASYNC) && bit_stb && bit_val;

   generate
      if (BITOR_EN) begin : g_bitor
         assign bor_start = (mode == MODE_BITOR) && bit_stb && bit_val && ones_at_thresh;
         assign bor_end   = (mode == MODE_BITOR) && bit_stb && !bit_val;
      end else begin : g_no_bitor
         assign bor_start = 1'b0;
         assign bor_end   = 1'b0;
      end
   endgenerate

   assign start_cond = async_start || bor_start;
   assign end_cond   = async_end || bor_end;
endmodule

// File: rtl/brk_ctl.sv
module brk_ctl
   import brk_abort_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic chan_rst,
   input  logic rearm,
   input  logic irq_en,
   input  logic char_vld,
   input  logic start_cond,
   input  logic end_cond,
   input  logic async_end,
   output logic stat_q,
   output logic pend_q,
   output logic disc_q
);
   brk_state_e st_q, st_d;
   logic start_evt, end_evt;

   assign start_evt = (st_q == ST_SEEK_START) && start_cond;
   assign end_evt   = (st_q == ST_SEEK_END) && end_cond;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_SEEK_START: if (start_evt) st_d = ST_HOLD_START;
         ST_HOLD_START: if (rearm)     st_d = ST_SEEK_END;
         ST_SEEK_END:   if (end_evt)   st_d = ST_HOLD_END;
         ST_HOLD_END:   if (rearm)     st_d = ST_SEEK_START;
         default:                      st_d = ST_SEEK_START;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_SEEK_START;
         stat_q <= 1'b0;
         pend_q <= 1'b0;
         disc_q <= 1'b0;
      end else if (chan_rst) begin
         st_q   <= ST_SEEK_START;
         stat_q <= 1'b0;
         pend_q <= 1'b0;
         disc_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (start_evt)
            stat_q <= 1'b1;
         else if (end_evt)
            stat_q <= 1'b0;
         if ((start_evt || end_evt) && irq_en)
            pend_q <= 1'b1;
         else if (rearm)
            pend_q <= 1'b0;
         if (end_evt && async_end)
            disc_q <= 1'b1;
         else if (char_vld)
            disc_q <= 1'b0;
      end
   end
endmodule

// File: rtl/brk_abort_det.sv
module brk_abort_det
   import brk_abort_pkg::*;
#(
   parameter int CHAR_W     = 8,
   parameter int ABORT_ONES = 7,
   parameter bit BITOR_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chan_rst,
   input  logic [1:0]        mode,
   input  logic              char_vld,
   input  logic [CHAR_W-1:0] char_data,
   input  logic              frame_err,
   input  logic              bit_stb,
   input  logic              bit_val,
   input  logic              rearm,
   input  logic              irq_en,
   output logic              brk_stat,
   output logic              irq_pend,
   output logic              discard_hint
);
   localparam int CNT_W = $clog2(ABORT_ONES + 1);

   generate
      if (CHAR_W < 5) begin : g_bad_char
         $error("brk_abort_det: CHAR_W must be at least 5");
      end
      if (ABORT_ONES < 2) begin : g_bad_ones
         $error("brk_abort_det: ABORT_ONES must be at least 2");
      end
   endgenerate

   brk_mode_e mode_e;
   logic      ones_at_thresh;
   logic      start_cond, end_cond, async_end;

   assign mode_e = brk_mode_e'(mode);

   generate
      if (BITOR_EN) begin : g_cnt
         brk_ones_cnt #(.ONES_LIM(ABORT_ONES), .CNT_W(CNT_W)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (chan_rst || (mode_e != MODE_BITOR)),
            .stb       (bit_stb),
            .bit_val   (bit_val),
            .at_thresh (ones_at_thresh)
         );
      end else begin : g_no_cnt
         assign ones_at_thresh = 1'b0;
      end
   endgenerate

   brk_evt_dec #(.CHAR_W(CHAR_W), .BITOR_EN(BITOR_EN)) u_dec (
      .mode           (mode_e),
      .char_vld       (char_vld),
      .char_data      (char_data),
      .frame_err      (frame_err),
      .bit_stb        (bit_stb),
      .bit_val        (bit_val),
      .ones_at_thresh (ones_at_thresh),
      .start_cond     (start_cond),
      .end_cond       (end_cond),
      .async_end      (async_end)
   );

   brk_ctl u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .chan_rst   (chan_rst),
      .rearm      (rearm),
      .irq_en     (irq_en),
      .char_vld   (char_vld),
      .start_cond (start_cond),
      .end_cond   (end_cond),
      .async_end  (async_end),
      .stat_q     (brk_stat),
      .pend_q     (irq_pend),
      .disc_q     (discard_hint)
   );
endmodule

// File: rtl/brk_abort_det_chk.sv
module brk_abort_det_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       chan_rst,
   input logic [1:0] mode,
   input logic       rearm,
   input logic       irq_en,
   input logic       char_vld,
   input logic       brk_stat,
   input logic       irq_pend,
   input logic       discard_hint
);
   AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_pend) |-> $past(irq_en)); // R4

   AST_PEND_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(brk_stat) && $past(irq_en)) |-> irq_pend); // R4

   AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_pend) |-> $past(rearm || chan_rst)); // R4

   AST_NO_EVT_OTHER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(brk_stat) |-> !$past(mode[1])); // R10

   AST_HINT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(discard_hint) |-> ($fell(brk_stat) && $past(mode) == 2'b00)); // R8

   AST_HINT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(discard_hint) |-> $past(char_vld || chan_rst)); // R8

   AST_CHAN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      chan_rst |=> (!brk_stat && !irq_pend && !discard_hint)); // R9
endmodule

bind brk_abort_det brk_abort_det_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .chan_rst     (chan_rst),
   .mode         (mode),
   .rearm        (rearm),
   .irq_en       (irq_en),
   .char_vld     (char_vld),
   .brk_stat     (brk_stat),
   .irq_pend     (irq_pend),
   .discard_hint (discard_hint)
);

// File: tb/brk_abort_det_test.sv
`timescale 1ns/1ps
module brk_abort_det_test;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          chan_rst = 1'b0;
   logic [1:0]    mode = 2'b00;
   logic          char_vld = 1'b0;
   logic [CW-1:0] char_data = '0;
   logic          frame_err = 1'b0;
   logic          bit_stb = 1'b0;
   logic          bit_val = 1'b0;
   logic          rearm = 1'b0;
   logic          irq_en = 1'b0;
   logic          brk_stat, irq_pend, discard_hint;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // reference state
   int m_st = 0;
   int m_cnt = 0;
   bit m_stat = 0, m_pend = 0, m_disc = 0;

   always #4 clk = ~clk;

   brk_abort_det uut (
      .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst), .mode(mode),
      .char_vld(char_vld), .char_data(char_data), .frame_err(frame_err),
      .bit_stb(bit_stb), .bit_val(bit_val), .rearm(rearm), .irq_en(irq_en),
      .brk_stat(brk_stat), .irq_pend(irq_pend), .discard_hint(discard_hint)
   );

   function automatic bit f_start(int st, int cnt);
      bit a = (mode == 2'b00) && char_vld && (char_data == '0) && frame_err;
      bit b = (mode == 2'b01) && bit_stb && bit_val && (cnt >= 6);
      return (st == 0) && (a || b);
   endfunction

   function automatic bit f_end(int st);
      bit a = (mode == 2'b00) && bit_stb && bit_val;
      bit b = (mode == 2'b01) && bit_stb && !bit_val;
      return (st == 2) && (a || b);
   endfunction

   task automatic model_step();
      bit s = f_start(m_st, m_cnt);
      bit e = f_end(m_st);
      if (chan_rst) begin
         m_st = 0; m_stat = 0; m_pend = 0; m_disc = 0; m_cnt = 0;
         return;
      end
      if (s) begin m_st = 1; m_stat = 1; end
      else if (e) begin m_st = 3; m_stat = 0; end
      else if (rearm && m_st == 1) m_st = 2;
      else if (rearm && m_st == 3) m_st = 0;
      if ((s || e) && irq_en) m_pend = 1;
      else if (rearm) m_pend = 0;
      if (e && mode == 2'b00) m_disc = 1;
      else if (char_vld) m_disc = 0;
      if (mode != 2'b01) m_cnt = 0;
      else if (bit_stb) m_cnt = bit_val ? ((m_cnt < 7) ? m_cnt + 1 : 7) : 0;
   endtask

   task automatic step();
      @(posedge clk);
      model_step();
      @(negedge clk);
      char_vld = 0; bit_stb = 0; rearm = 0; chan_rst = 0; frame_err = 0;
      char_data = '1;
   endtask

   task automatic chk(string tag, bit act, bit exp, string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
      end
   endtask

   task automatic chk3(string tag, bit s, bit p, bit d);
      chk(tag, brk_stat, s, "brk_stat");
      chk(tag, irq_pend, p, "irq_pend");
      chk(tag, discard_hint, d, "discard_hint");
   endtask

   task automatic send_char(logic [CW-1:0] c, bit fe);
      char_vld = 1; char_data = c; frame_err = fe; step();
   endtask

   task automatic send_bit(bit b);
      bit_stb = 1; bit_val = b; step();
   endtask

   task automatic do_rearm();
      rearm = 1; step();
   endtask

   initial begin
      #1600000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk); @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk3("R9_reset", 0, 0, 0);

      // asynchronous directed
      irq_en = 1; mode = 2'b00;
      send_char(8'h01, 1); chk("R2", brk_stat, 0, "nonzero char");
      send_char(8'h00, 0); chk("R2", brk_stat, 0, "zero no fe");
      send_char(8'h00, 1); chk3("R1", 1, 1, 0);
      send_bit(1);         chk("R5", brk_stat, 1, "end before rearm");
      step();              chk("R4", irq_pend, 1, "pend holds");
      do_rearm();          chk3("R4", 1, 0, 0);
      send_bit(0);         chk("R6", brk_stat, 1, "zero bit async");
      send_bit(1);         chk3("R6", 0, 1, 1);
      step();              chk("R8", discard_hint, 1, "hint holds");
      send_char(8'h00, 1); chk("R7", brk_stat, 0, "start before rearm");
      chk("R8", discard_hint, 0, "hint cleared by char");
      do_rearm();          chk("R7", irq_pend, 0, "rearm clears");
      rearm = 1; char_vld = 1; char_data = 8'h00; frame_err = 1; step();
      chk3("R4_same_cycle", 1, 1, 0);
      chan_rst = 1; step(); chk3("R9_chan", 0, 0, 0);

      // bit-oriented directed
      mode = 2'b01; irq_en = 0;
      for (int i = 0; i < 6; i++) send_bit(1);
      send_bit(0); send_bit(1);
      chk("R11", brk_stat, 0, "count cleared by zero");
      for (int i = 0; i < 5; i++) send_bit(1);
      chk("R3", brk_stat, 0, "six ones");
      send_bit(1);
      chk("R3", brk_stat, 1, "seventh one");
      chk("R4", irq_pend, 0, "irq disabled");
      do_rearm();
      for (int i = 0; i < 4; i++) send_bit(1);
      chk("R11", brk_stat, 1, "extra ones");
      send_bit(0);
      chk3("R6", 0, 0, 0);
      do_rearm();
      for (int i = 0; i < 3; i++) send_bit(1);
      chk("R11", brk_stat, 0, "saturated count cleared");

      // other synchronous modes
      mode = 2'b10; irq_en = 1;
      send_char(8'h00, 1);
      for (int i = 0; i < 10; i++) send_bit(1);
      chk3("R10", 0, 0, 0);
      mode = 2'b11;
      send_char(8'h00, 1);
      for (int i = 0; i < 10; i++) send_bit(1);
      chk3("R10", 0, 0, 0);

      // constrained random against the reference functions
      void'($urandom(32'h5A17));
      for (int i = 0; i < 4000; i++) begin
         mode      = ($urandom_range(0, 9) == 0) ? 2'(($urandom_range(0, 3))) :
                     ((i / 500) % 2 == 0 ? 2'b00 : 2'b01);
         irq_en    = ($urandom_range(0, 4) != 0);
         char_vld  = ($urandom_range(0, 5) == 0);
         char_data = ($urandom_range(0, 2) == 0) ? 8'h00 : 8'($urandom);
         frame_err = ($urandom_range(0, 1) == 0);
         bit_stb   = ($urandom_range(0, 1) == 0);
         bit_val   = ($urandom_range(0, 9) < 8);
         rearm     = ($urandom_range(0, 11) == 0);
         chan_rst  = ($urandom_range(0, 299) == 0);
         step();
         chk3("R1/R3/R4/R6/R7/R8", m_stat, m_pend, m_disc);
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule